// File: doc/BRIEF.md
# Sense-Reversing Barrier Controller

This block makes a group of P participants meet at a common point before any of them continues. It keeps one arrival counter, loaded with P, and a single global phase bit. A participant raises its arrive strobe for one cycle when it reaches the barrier. It also holds a local phase level that it has flipped to the value it expects the global phase to take next. Each accepted arrival takes one off the counter. Several ports may arrive in the same cycle, and the counter then drops by the number of new arrivals.

When the arrivals bring the counter to zero, the block reloads it to P and inverts the global phase in the same cycle. Every port whose local phase now matches the global phase sees its release output go high. The same counter and phase bit then serve the next episode without a separate reset phase. A port that arrives a second time within one episode gets a protocol-error pulse, and that arrival is discarded.

Top module: `sense_barrier`

## Requirements
- R1: After reset the counter output equals P (4 by default), the global phase output is 0 and no error is flagged.
- R2: A single accepted arrival lowers the counter by one on the next clock edge and leaves the global phase unchanged.
- R3: Arrivals from several ports in one cycle lower the counter by the number of accepted arrivals on the next clock edge.
- R4: The global phase does not change while fewer than P ports have arrived in the current episode, and the counter stays within 1 to P.
- R5: The arrival that completes the episode makes the counter read P and the global phase invert on the next clock edge.
- R6: release[i] is high exactly when local phase input i equals the global phase output.
- R7: An arrival from a port that has already arrived in the current episode raises that port's error bit in the same cycle. It does not change the counter or the global phase.
- R8: All P ports arriving in one cycle complete the episode at once, and the counter reloads to P.
- R9: Successive episodes reuse the counter and phase bit without reset. A port that holds a local phase left over from the previous episode is not released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive | input | P | One-cycle arrival strobe per port |
| local_phase | input | P | Phase level each port waits for |
| release_o | output | P | Per-port release, local phase equals global phase |
| proto_err | output | P | Repeat arrival within one episode |
| phase_o | output | 1 | Global phase bit |
| count_o | output | $clog2(P+1) | Remaining arrivals in this episode |

## Verification
The bench drives single arrivals, several arrivals in one cycle, an episode finished by all ports at once, and repeat arrivals mixed with valid ones in the same cycle. A design that counted strobes rather than new arrivals would drop the counter too far on a repeat, and the phase would then flip before every port had met. A design that compared against zero instead of the arrival count would wrap the counter when all ports arrive together. The bench also checks release against both phase values, so a design that latched release or ignored a stale local phase would let a port through early.

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int P = 4,
  localparam int CW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [P-1:0]  arrive,
  input  logic [P-1:0]  local_phase,
  output logic [P-1:0]  release_o,
  output logic [P-1:0]  proto_err,
  output logic          phase_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] FULL = CW'(P);

  logic [CW-1:0] count_q;
  logic          phase_q;
  logic [P-1:0]  seen_q;
  logic [P-1:0]  accepted;
  logic [CW-1:0] n_acc;
  logic          done;

  assign accepted  = arrive & ~seen_q;
  assign proto_err = arrive & seen_q;

  always_comb begin
    n_acc = '0;
    for (int i = 0; i < P; i++) n_acc = n_acc + CW'(accepted[i]);
  end

  assign done = (n_acc == count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= FULL;
      phase_q <= 1'b0;
      seen_q  <= '0;
    end else if (done) begin
      count_q <= FULL;
      phase_q <= ~phase_q;
      seen_q  <= '0;
    end else begin
      count_q <= count_q - n_acc;
      seen_q  <= seen_q | accepted;
    end
  end

  assign release_o = ~(local_phase ^ {P{phase_q}});
  assign phase_o   = phase_q;
  assign count_o   = count_q;

  // R3
  partial_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'($countones(arrive & ~proto_err)) < count_q)
      |=> count_q == $past(count_q) - CW'($countones($past(arrive & ~proto_err))));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q != '0 && count_q <= FULL);

  // R5
  flip_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> count_q == FULL);

  // R7
  repeat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive != '0 && arrive == proto_err) |=> ($stable(count_q) && $stable(phase_q)));

endmodule

// File: tb/sense_barrier_test.sv
module sense_barrier_test;
  localparam int P = 4;
  logic clk = 0, rst_n = 0;
  logic [P-1:0] arrive = '0, local_phase = '0;
  logic [P-1:0] release_o, proto_err;
  logic phase_o;
  logic [2:0] count_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sense_barrier #(.P(P)) uut (.clk, .rst_n, .arrive, .local_phase,
    .release_o, .proto_err, .phase_o, .count_o);

  // {arrive[4], expected err[4], expected count[3], expected phase[1]}
  localparam logic [11:0] VEC [8] = '{
    {4'b0001, 4'b0000, 3'd3, 1'b0},   // R2
    {4'b0110, 4'b0000, 3'd1, 1'b0},   // R3
    {4'b0001, 4'b0001, 3'd1, 1'b0},   // R7 repeat only
    {4'b1000, 4'b0000, 3'd4, 1'b1},   // R5
    {4'b1111, 4'b0000, 3'd4, 1'b0},   // R8
    {4'b0011, 4'b0000, 3'd2, 1'b0},   // R3 R9
    {4'b0111, 4'b0011, 3'd1, 1'b0},   // R7 mixed
    {4'b1000, 4'b0000, 3'd4, 1'b1}    // R5 R9
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 count", 8'(count_o), 8'd4);
    chk("R1 phase", 8'(phase_o), 8'd0);
    chk("R1 err", 8'(proto_err), 8'd0);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      arrive = VEC[v][11:8];
      #1;
      chk($sformatf("R7 err vec%0d", v), 8'(proto_err), 8'(VEC[v][7:4]));
      @(negedge clk);
      arrive = '0;
      chk($sformatf("R2/R3/R5 count vec%0d", v), 8'(count_o), 8'(VEC[v][3:1]));
      chk($sformatf("R4/R5 phase vec%0d", v), 8'(phase_o), 8'(VEC[v][0]));
    end

    // phase is 1 now
    local_phase = 4'b1111; #1;
    chk("R6 all match", 8'(release_o), 8'hf);
    local_phase = 4'b0101; #1;
    chk("R6 partial", 8'(release_o), 8'h5);
    local_phase = 4'b0000; #1;
    chk("R9 stale phase held", 8'(release_o), 8'h0);

    // next episode: ports flip local phase to 0 and arrive one by one
    local_phase = 4'b0000;
    @(negedge clk); arrive = 4'b0100;
    @(negedge clk); arrive = '0; #1;
    chk("R9 released early", 8'(release_o), 8'h0);
    chk("R4 phase held", 8'(phase_o), 8'd1);
    @(negedge clk); arrive = 4'b1011;
    @(negedge clk); arrive = '0; #1;
    chk("R9 phase after reuse", 8'(phase_o), 8'd0);
    chk("R6 release after reuse", 8'(release_o), 8'hf);
    chk("R5 count reload", 8'(count_o), 8'd4);

    // reset mid-episode
    @(negedge clk); arrive = 4'b0001;
    @(negedge clk); arrive = '0; rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 reset count", 8'(count_o), 8'd4);
    @(negedge clk); arrive = 4'b0001; #1;
    chk("R1 seen cleared", 8'(proto_err), 8'd0);
    @(negedge clk); arrive = '0;
    chk("R2 after reset", 8'(count_o), 8'd3);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule